// File: doc/BRIEF.md
# Shared Multiprocessor Control and Interrupt Flag Register

This block is one 64-bit control and status word that four processors share. It holds one interprocessor-interrupt flag and one interval-timer-interrupt flag for each processor, two 4-bit arbitration fields and a plain read/write nibble. Each flag drives its own interrupt output, so a processor can post an interrupt to any other processor with one store.

Each field has its own write rule. Some fields clear where a one is written, some set where a one is written, and one field accepts ones only while it is empty. A separate request nibble sets interprocessor flags as a side effect of the write.

All rules act in one clock edge, in this order: clears, then the arbitration clear, then sets. A per-processor timer pulse input sets the timer flags. A read is combinational. It returns the stored word with the two lowest bits replaced by the index of the requesting processor.

Top module: `mpc_reg`

## Requirements
- R1: On a write, every bit written as 1 in the interprocessor flag field (bits 11:8) or the timer flag field (bits 7:4) is cleared. Bit 28 is also write-one-to-clear, has no setter, and reads 0.
- R2: Writing 1 to bit 20 clears both arbitration fields (bits 23:16) before any set rule of the same write is applied.
- R3: The arbitration-try field (bits 23:20) is write-one-to-set. Ones written there are ORed in after the clear of R2.
- R4: The arbitration-won field (bits 19:16) takes the written ones only if, after the clear of R2, it holds all zeros. Otherwise it keeps its value.
- R5: A 1 written to request bit 12+i sets interprocessor flag bit 8+i. A request set wins over a clear of the same flag in the same write.
- R6: Bits 43:40 are replaced by the written data on every write.
- R7: rd_data equals the stored word with bits 1:0 replaced by req_id. All bits not named in R1 to R6 read 0.
- R8: ipi_irq[i] equals flag bit 8+i and timer_irq[i] equals flag bit 4+i. A timer flag becomes 1 only through timer_set.
- R9: timer_set[i] sets timer flag bit 4+i. It wins over a write that clears the same bit in the same cycle.
- R10: Without wr_en the flags and fields change only through timer_set. An asserted rst_n low clears every stored bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the register |
| wr_data | input | 64 | Write data |
| req_id | input | 2 | Index of the processor making the access |
| timer_set | input | 4 | Per-processor interval timer set pulses |
| rd_data | output | 64 | Read data, with bits 1:0 set to req_id |
| ipi_irq | output | 4 | Per-processor interprocessor interrupt |
| timer_irq | output | 4 | Per-processor interval timer interrupt |

## Verification
The assertions take the inputs to be two-state and held steady around each rising edge. They also take wr_data to be free to carry any pattern, including a clear and a set of the same flag in one write, and a timer pulse that coincides with a write. The bench drives every input at the falling edge. It sweeps all 256 values of the arbitration byte, which covers every combination of the clear bit, the try nibble and the won nibble against prior states built up by earlier writes. The remaining write bits, the timer pulses, the write strobe and the requester index come from a linear feedback shift register, so every value stays a legal two-state stimulus.

// File: rtl/mpc_pkg.sv
package mpc_pkg;
    localparam int NPROC     = 4;
    localparam int WORD_W    = 64;
    localparam int ID_W      = $clog2(NPROC);
    localparam int ARB_W     = 4;
    localparam int RW_W      = 4;
    localparam int TMR_LSB   = 4;
    localparam int IPI_LSB   = 8;
    localparam int REQ_LSB   = 12;
    localparam int WON_LSB   = 16;
    localparam int TRY_LSB   = 20;
    localparam int ACLR_BIT  = 20;
    localparam int ERR_BIT   = 28;
    localparam int RW_LSB    = 40;

    typedef struct packed {
        logic [RW_W-1:0]  rw;
        logic [ARB_W-1:0] try_f;
        logic [ARB_W-1:0] won;
        logic [NPROC-1:0] ipi;
        logic [NPROC-1:0] tmr;
    } mpc_state_t;
endpackage

// File: rtl/mpc_next.sv
module mpc_next
    import mpc_pkg::*;
(
    input  mpc_state_t        cur_q,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [NPROC-1:0]  timer_set,
    output mpc_state_t        nxt_d
);
    logic [NPROC-1:0] tset_v;

    // one set path per processor
    for (genvar gi = 0; gi < NPROC; gi++) begin : g_tset
        assign tset_v[gi] = timer_set[gi];
    end

    always_comb begin
        nxt_d = cur_q;
        if (wr_en) begin
            // stage 1: write-one-to-clear
            nxt_d.ipi = nxt_d.ipi & ~wr_data[IPI_LSB +: NPROC];
            nxt_d.tmr = nxt_d.tmr & ~wr_data[TMR_LSB +: NPROC];
            // stage 2: arbitration clear
            if (wr_data[ACLR_BIT]) begin
                nxt_d.won   = '0;
                nxt_d.try_f = '0;
            end
            // stage 3: set rules
            nxt_d.try_f = nxt_d.try_f | wr_data[TRY_LSB +: ARB_W];
            if (nxt_d.won == '0) begin
                nxt_d.won = wr_data[WON_LSB +: ARB_W];
            end
            nxt_d.ipi = nxt_d.ipi | wr_data[REQ_LSB +: NPROC];
            nxt_d.rw  = wr_data[RW_LSB +: RW_W];
        end
        // timer pulses come last and so win over a clear
        nxt_d.tmr = nxt_d.tmr | tset_v;
    end
endmodule

// File: rtl/mpc_rd_merge.sv
module mpc_rd_merge
    import mpc_pkg::*;
(
    input  mpc_state_t        cur_q,
    input  logic [ID_W-1:0]   req_id,
    output logic [WORD_W-1:0] rd_data
);
    always_comb begin
        rd_data = '0;
        rd_data[TMR_LSB +: NPROC] = cur_q.tmr;
        rd_data[IPI_LSB +: NPROC] = cur_q.ipi;
        rd_data[WON_LSB +: ARB_W] = cur_q.won;
        rd_data[TRY_LSB +: ARB_W] = cur_q.try_f;
        rd_data[RW_LSB +: RW_W]   = cur_q.rw;
        rd_data[ERR_BIT]          = 1'b0;
        rd_data[ID_W-1:0]         = req_id;
    end
endmodule

// File: rtl/mpc_reg.sv
module mpc_reg
    import mpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [63:0]       wr_data,
    input  logic [1:0]        req_id,
    input  logic [3:0]        timer_set,
    output logic [63:0]       rd_data,
    output logic [3:0]        ipi_irq,
    output logic [3:0]        timer_irq
);
    mpc_state_t st_q;
    mpc_state_t st_d;

    mpc_next u_next (
        .cur_q     (st_q),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .timer_set (timer_set),
        .nxt_d     (st_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    mpc_rd_merge u_rd (
        .cur_q   (st_q),
        .req_id  (req_id),
        .rd_data (rd_data)
    );

    assign ipi_irq   = st_q.ipi;
    assign timer_irq = st_q.tmr;
endmodule

// File: rtl/mpc_reg_chk.sv
module mpc_reg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [63:0] wr_data,
    input logic [1:0]  req_id,
    input logic [3:0]  timer_set,
    input logic [63:0] rd_data,
    input logic [3:0]  ipi_irq,
    input logic [3:0]  timer_irq
);
    // R1: written-1 flags with no matching request are cleared
    a_r1_ipi_clear: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((ipi_irq & $past(wr_data[11:8] & ~wr_data[15:12])) == 4'b0));

    // R5: a request bit always leaves its flag set
    a_r5_ipi_request: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((ipi_irq & $past(wr_data[15:12])) == $past(wr_data[15:12])));

    // R9: timer pulse wins over everything
    a_r9_timer_set: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_set != 4'b0) |=> ((timer_irq & $past(timer_set)) == $past(timer_set)));

    // R8: a timer flag rises only because of a pulse
    a_r8_timer_only_by_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((timer_irq & ~$past(timer_irq) & ~$past(timer_set)) == 4'b0));

    // R10: no write leaves interprocessor flags and the read word upper part unchanged
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(ipi_irq) && $stable(rd_data[63:8])));

    // R3: try field keeps prior ones unless the clear bit is written
    a_r3_try_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[20]) |=>
            ((rd_data[23:20] & $past(rd_data[23:20])) == $past(rd_data[23:20])));

    // R6: plain nibble follows write data
    a_r6_rw_field: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[43:40] == $past(wr_data[43:40])));

    // R7: requester index merged into the read word
    always_comb begin
        if (rst_n) begin
            a_r7_id_merge: assert (rd_data[1:0] == req_id);
        end
    end
endmodule

bind mpc_reg mpc_reg_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .req_id    (req_id),
    .timer_set (timer_set),
    .rd_data   (rd_data),
    .ipi_irq   (ipi_irq),
    .timer_irq (timer_irq)
);

// File: tb/sim_mpc_reg.sv
module sim_mpc_reg;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [63:0] wr_data;
    logic [1:0]  req_id;
    logic [3:0]  timer_set;
    logic [63:0] rd_data;
    logic [3:0]  ipi_irq;
    logic [3:0]  timer_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [63:0] model;
    logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

    always #(CLK_PERIOD/2) clk = ~clk;

    mpc_reg u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .req_id(req_id), .timer_set(timer_set), .rd_data(rd_data),
        .ipi_irq(ipi_irq), .timer_irq(timer_irq)
    );

    function automatic logic [63:0] ref_next(logic [63:0] s, logic we,
                                             logic [63:0] w, logic [3:0] ts);
        logic [63:0] n;
        n = s;
        if (we) begin
            n = n & ~(w & 64'h0000_0000_1000_0FF0);
            if (w[20]) n = n & ~64'h0000_0000_00FF_0000;
            n = n | (w & 64'h0000_0000_00F0_0000);
            if (n[19:16] == 4'h0) n[19:16] = w[19:16];
            n[11:8]  = n[11:8] | w[15:12];
            n[43:40] = w[43:40];
        end
        n[7:4] = n[7:4] | ts;
        return n;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cycle(logic we, logic [63:0] w, logic [3:0] ts, logic [1:0] id);
        @(negedge clk);
        wr_en = we; wr_data = w; timer_set = ts; req_id = id;
        model = ref_next(model, we, w, ts);
        @(posedge clk);
        #(CLK_PERIOD/4);
        wr_en = 1'b0; timer_set = 4'b0;
    endtask

    task automatic check_all(logic [1:0] id);
        logic [63:0] e;
        e = {model[63:2], id};
        check("R1 timer/ipi clears", rd_data & 64'h0000_0000_1000_0FF0, e & 64'h0000_0000_1000_0FF0);
        check("R3 try field",  {60'b0, rd_data[23:20]}, {60'b0, e[23:20]});
        check("R4 won field",  {60'b0, rd_data[19:16]}, {60'b0, e[19:16]});
        check("R6 rw field",   {60'b0, rd_data[43:40]}, {60'b0, e[43:40]});
        check("R7 full word",  rd_data, e);
        check("R8 ipi out",    {60'b0, ipi_irq},   {60'b0, e[11:8]});
        check("R8 timer out",  {60'b0, timer_irq}, {60'b0, e[7:4]});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; timer_set = '0; req_id = '0;
        model = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R10 reset state, R7 id merge for every requester
        for (int i = 0; i < 4; i++) begin
            req_id = 2'(i); #1;
            check("R10 reset word", rd_data, {62'b0, 2'(i)});
        end
        // R5 request sets, then R1 clear of the same flags
        cycle(1'b1, 64'h0000_0000_0000_5000, 4'b0, 2'd1); check_all(2'd1);
        check("R5 request sets ipi", {60'b0, ipi_irq}, 64'h5);
        cycle(1'b1, 64'h0000_0000_0000_0100, 4'b0, 2'd2); check_all(2'd2);
        check("R1 ipi cleared", {60'b0, ipi_irq}, 64'h4);
        // R5 set wins over clear of same flag
        cycle(1'b1, 64'h0000_0000_0000_2200, 4'b0, 2'd0); check_all(2'd0);
        check("R5 set beats clear", {60'b0, ipi_irq}, 64'h6);
        // R4 won accepts only when empty
        cycle(1'b1, 64'h0000_0000_0003_0000, 4'b0, 2'd0);
        cycle(1'b1, 64'h0000_0000_000C_0000, 4'b0, 2'd0); check_all(2'd0);
        check("R4 won kept", {60'b0, rd_data[19:16]}, 64'h3);
        // R2 clear then won reloads in same write, try set bit 20
        cycle(1'b1, 64'h0000_0000_009C_0000, 4'b0, 2'd3); check_all(2'd3);
        check("R2 clear then set", {56'b0, rd_data[23:16]}, 64'h9C);
        // R9 timer pulse beats write clear
        cycle(1'b0, 64'h0, 4'b1010, 2'd0);
        cycle(1'b1, 64'h0000_0000_0000_00F0, 4'b0010, 2'd0); check_all(2'd0);
        check("R9 pulse beats clear", {60'b0, timer_irq}, 64'h2);
        // R10 no write: garbage data ignored
        cycle(1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 4'b0, 2'd1); check_all(2'd1);
        // R1 bit 28 clear has nothing to clear and reads 0
        cycle(1'b1, 64'h0000_0000_1000_0000, 4'b0, 2'd1); check_all(2'd1);
        check("R1 bit28 reads 0", {63'b0, rd_data[28]}, 64'h0);
        // sweep of arbitration byte with pseudo-random remainder
        for (int a = 0; a < 256; a++) begin
            logic [63:0] w;
            lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
            w = lfsr;
            w[23:16] = 8'(a);
            cycle(lfsr[5] | lfsr[9], w, lfsr[33:30] & {4{lfsr[2]}}, lfsr[41:40]);
            check_all(lfsr[41:40]);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule